// File: doc/BRIEF.md
# Comma Detect and Byte Aligner

This block takes a retimed serial bit stream, one bit per bit clock, and rebuilds 10-bit characters from it. A sliding 10-bit window is compared on every bit against the positive-disparity comma pattern. When alignment is enabled, a comma that does not sit on the current character boundary moves the boundary onto it. The recovered characters are presented on a parallel output together with two complementary byte clocks at half the character rate. Successive characters appear on the rising edges of the two clocks in turn.

A realignment never shortens a byte-clock phase. The clocks are instead held for whole character periods until the new boundary is reached. Commas are steered onto rising edges of byte clock 1. If a comma falls where clock 0 would rise, the clocks are held for one more character. The second comma of a link is therefore always presented on clock 1. With alignment disabled, the character grid runs freely from reset and commas neither move it nor raise the sync flag.

Top module: `comma_align_top`

## Requirements
- R1: While reset is asserted, rxData is 0, byteClk1 is low, byteClk0 is high and syncFlag is low.
- R2: The first bit received of a character lands in rxData[0]. After reset is released, the character made of serial bits 0..9 appears at the 11th bit-clock edge, with a rising edge of byteClk1. rxData changes only together with a byte-clock edge.
- R3: byteClk0 is always the complement of byteClk1. Without realignment, each clock phase lasts 10 bit periods, and the characters alternate between rising edges of byteClk1 and byteClk0, with byteClk1 first.
- R4: A comma is present when the seven oldest bits of the window, in arrival order, are 0,0,1,1,1,1,1 (LSB-first value 0x07C in bits 6..0; bits 9..7 are ignored). syncFlag goes high for exactly one bit period, at the edge after the comma's tenth bit was sampled.
- R5: syncFlag never goes high while alignEn is low.
- R6: A comma found on the current boundary, at a position whose byte-clock edge is on byteClk1, changes neither the grid nor the clock timing.
- R7: A comma off the current boundary restarts the grid, so the next boundary falls 10 bits after the comma. The byte clocks hold their level meanwhile. No byte-clock phase is ever shorter than 10 bit periods.
- R8: With alignEn high, every comma presented on rxData comes with a rising edge of byteClk1. A comma that falls where byteClk0 would rise is not presented, and the clocks are held one character longer. The second comma of a stream is therefore presented on byteClk1.
- R9: With alignEn low, commas have no effect. Characters are cut from the grid set at reset, one every 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Synchronous active-low reset |
| serialIn | input | 1 | Retimed serial data, one bit per clock |
| alignEn | input | 1 | High enables comma alignment and the sync flag |
| rxData | output | WORD_W | Recovered character, bit 0 received first |
| byteClk0 | output | 1 | Byte clock 0, complement of byteClk1 |
| byteClk1 | output | 1 | Byte clock 1, rises on commas |
| syncFlag | output | 1 | One-bit pulse on a detected comma while enabled |

## Verification
The following are checked on every cycle by the assertions:
- the two byte clocks stay complementary;
- no clock phase is shorter than a character;
- data changes only at a clock edge;
- the sync flag is a single pulse, and only while enabled;
- a free-running boundary always toggles the clocks;
- an on-boundary comma either raises clock 1 or holds the clocks.

The bench scenarios show what the assertions cannot: bit order, the exact edge on which the first character appears, and the characters presented after a misaligned comma. They also show that a wrong-parity comma is dropped and the second comma is presented on clock 1, and that a disabled block keeps its reset grid while commas pass through.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

  // Strobes from control to datapath for one character boundary
  typedef struct packed {
    logic loadWord;   // capture the window into the output register
    logic flipClk;    // toggle both byte clocks
  } alignStrobe_t;

endpackage

// File: rtl/comma_align_dp.sv
module comma_align_dp
  import comma_align_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  alignStrobe_t      strobe,
  output logic              commaHit,
  output logic [WORD_W-1:0] rxData,
  output logic              byteClk0,
  output logic              byteClk1
);

  // Sliding window: newest bit enters at the top, oldest sits in bit 0
  logic [WORD_W-1:0]  shiftReg;
  logic [COMMA_W-1:0] bitMatch;
  logic               clk0Reg;
  logic               clk1Reg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else begin
      shiftReg <= {serialIn, shiftReg[WORD_W-1:1]};
    end
  end

  // Per-bit pattern compare over the oldest COMMA_W bits
  for (genvar i = 0; i < COMMA_W; i++) begin : g_match
    assign bitMatch[i] = (shiftReg[i] == COMMA_PAT[i]);
  end

  assign commaHit = &bitMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (strobe.loadWord) begin
      rxData <= shiftReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clk1Reg <= 1'b0;
      clk0Reg <= 1'b1;
    end else if (strobe.flipClk) begin
      clk1Reg <= ~clk1Reg;
      clk0Reg <= ~clk0Reg;
    end
  end

  assign byteClk0 = clk0Reg;
  assign byteClk1 = clk1Reg;

endmodule

// File: rtl/comma_align_ctrl.sv
module comma_align_ctrl
  import comma_align_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         alignEn,
  input  logic         commaHit,
  input  logic         clkPhase,
  output alignStrobe_t strobe,
  output logic         syncFlag
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int PH_W  = $clog2(4 * WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
  localparam logic [PH_W-1:0]  PH_MIN   = PH_W'(WORD_W);
  localparam logic [PH_W-1:0]  PH_MAX   = PH_W'(4 * WORD_W);

  logic [CNT_W-1:0] bitCnt;      // bits of the current character in the window
  logic             curEven;     // parity of the character being assembled
  logic             atBoundary;
  logic             huntHit;
  logic             gridEvent;
  logic             charEven;
  logic             parityOk;
  logic             fire;
  logic [PH_W-1:0]  phaseCnt;    // bit periods since last clock toggle

  assign atBoundary = (bitCnt == FULL_CNT);
  assign huntHit    = alignEn && commaHit;
  assign gridEvent  = atBoundary || huntHit;
  assign charEven   = huntHit ? 1'b1 : curEven;
  // Even characters must raise clock 1, odd ones clock 0
  assign parityOk   = charEven ? !clkPhase : clkPhase;
  assign fire       = atBoundary && (!alignEn || parityOk);

  always_comb begin
    strobe.loadWord = fire;
    strobe.flipClk  = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      curEven <= 1'b1;
    end else if (gridEvent) begin
      bitCnt  <= CNT_W'(1);
      curEven <= ~charEven;
    end else begin
      bitCnt  <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncFlag <= 1'b0;
    end else begin
      syncFlag <= huntHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (fire) begin
      phaseCnt <= PH_W'(1);
    end else if (phaseCnt != PH_MAX) begin
      phaseCnt <= phaseCnt + PH_W'(1);
    end
  end

  // R7: a byte clock phase never ends before a full character period
  p_phase_min_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flipClk |-> (phaseCnt >= PH_MIN));

  // R5: sync only follows an enabled cycle
  p_sync_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |-> $past(alignEn));

  // R4: sync is a single bit-period pulse
  p_sync_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |=> !syncFlag);

  // R9: with alignment off, every boundary toggles the clocks
  p_free_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!alignEn && atBoundary) |=> !$stable(clkPhase));

  // R8: an on-boundary comma either raises clock 1 or holds the clocks
  p_comma_on_clk1_r8: assert property (@(posedge clk) disable iff (!rstN)
    (huntHit && atBoundary) |=> (clkPhase || $stable(clkPhase)));

endmodule

// File: rtl/comma_align_top.sv
module comma_align_top
  import comma_align_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              alignEn,
  output logic [WORD_W-1:0] rxData,
  output logic              byteClk0,
  output logic              byteClk1,
  output logic              syncFlag
);

  alignStrobe_t strobe;
  logic         commaHit;

  comma_align_dp #(
    .WORD_W   (WORD_W),
    .COMMA_W  (COMMA_W),
    .COMMA_PAT(COMMA_PAT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serialIn(serialIn),
    .strobe  (strobe),
    .commaHit(commaHit),
    .rxData  (rxData),
    .byteClk0(byteClk0),
    .byteClk1(byteClk1)
  );

  comma_align_ctrl #(
    .WORD_W(WORD_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .alignEn (alignEn),
    .commaHit(commaHit),
    .clkPhase(byteClk1),
    .strobe  (strobe),
    .syncFlag(syncFlag)
  );

  // R3: the byte clocks are always complementary
  p_clk_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({byteClk0, byteClk1}));

  // R2: new data only appears together with a byte clock edge
  p_data_with_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> !$stable(byteClk1));

endmodule

// File: tb/test_comma_align_top.sv
module test_comma_align_top;

  localparam int WORD_W = 10;
  localparam logic [9:0] K_CH = 10'h17C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b0;
  logic       alignEn = 1'b1;
  logic [9:0] rxData;
  logic       byteClk0;
  logic       byteClk1;
  logic       syncFlag;

  always #2 clk = ~clk;

  comma_align_top #(.WORD_W(WORD_W)) i_comma_align_top (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .alignEn(alignEn),
    .rxData(rxData), .byteClk0(byteClk0), .byteClk1(byteClk1),
    .syncFlag(syncFlag)
  );

  // Vector table: {expected on byteClk1, character}; stimulus equals expected data
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 10'h17C}, {1'b0, 10'h155}, {1'b1, 10'h2AA}, {1'b0, 10'h0CC},
    {1'b1, 10'h17C}, {1'b0, 10'h333}, {1'b1, 10'h199}, {1'b0, 10'h266}
  };

  int   total = 0;
  int   bad = 0;
  logic streamBits [0:511];
  int   streamLen;
  logic [9:0] capData [0:63];
  logic       capClk  [0:63];
  int   capCycle [0:63];
  int   capCount, syncCount, firstSync, minPhase;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearStream();
    streamLen = 0;
  endtask

  task automatic pushBit(input logic b);
    streamBits[streamLen] = b;
    streamLen++;
  endtask

  task automatic pushChar(input logic [9:0] c);
    for (int i = 0; i < 10; i++) pushBit(c[i]);
  endtask

  function automatic logic [9:0] gridWord(input int k);
    logic [9:0] w;
    for (int b = 0; b < 10; b++) w[b] = streamBits[10 * k + b];
    return w;
  endfunction

  task automatic play(input logic en);
    int   cycle, lastFlip, w;
    logic prev0, prev1;
    alignEn = en;
    rstN = 1'b0;
    serialIn = 1'b0;
    repeat (3) @(negedge clk);
    check(rxData == 10'h0, "R1 rxData in reset", rxData, 0);
    check(byteClk1 == 1'b0, "R1 byteClk1 in reset", byteClk1, 0);
    check(byteClk0 == 1'b1, "R1 byteClk0 in reset", byteClk0, 1);
    check(syncFlag == 1'b0, "R1 syncFlag in reset", syncFlag, 0);
    rstN = 1'b1;
    serialIn = streamBits[0];
    cycle = 0; lastFlip = 0; prev0 = byteClk0; prev1 = byteClk1;
    capCount = 0; syncCount = 0; firstSync = -1; minPhase = 1000;
    for (int i = 1; i < streamLen + 4; i++) begin
      @(negedge clk);
      cycle++;
      if ((byteClk1 && !prev1) || (byteClk0 && !prev0)) begin
        if (capCount < 64) begin
          capData[capCount]  = rxData;
          capClk[capCount]   = byteClk1;
          capCycle[capCount] = cycle;
          capCount++;
        end
      end
      if (byteClk1 != prev1) begin
        w = cycle - lastFlip;
        if (w < minPhase) minPhase = w;
        lastFlip = cycle;
      end
      if (syncFlag) begin
        syncCount++;
        if (firstSync < 0) firstSync = cycle;
      end
      prev0 = byteClk0;
      prev1 = byteClk1;
      serialIn = (i < streamLen) ? streamBits[i] : 1'b0;
    end
  endtask

  task automatic buildOffsetStream();
    clearStream();
    pushBit(1'b0); pushBit(1'b1); pushBit(1'b0);
    pushChar(10'h155); pushChar(K_CH); pushChar(10'h2AA); pushChar(10'h0CC);
    pushChar(10'h333); pushChar(K_CH); pushChar(10'h199); pushChar(10'h266);
    pushChar(10'h155); pushChar(10'h2AA); pushChar(10'h0CC);
  endtask

  initial begin
    // Table walk: commas on even aligned positions, no clock change (R6)
    clearStream();
    for (int k = 0; k < 8; k++) pushChar(VEC[k][9:0]);
    pushChar(10'h155); pushChar(10'h2AA);
    play(1'b1);
    check(capCount >= 8, "R2 table capture count", capCount, 8);
    for (int k = 0; k < 8; k++) begin
      check(capData[k] == VEC[k][9:0], "R2 R6 table data", capData[k], VEC[k][9:0]);
      check(capClk[k] == VEC[k][10], "R3 table clock", capClk[k], VEC[k][10]);
    end
    check(capCycle[0] == 11, "R2 first character edge", capCycle[0], 11);
    check(capCycle[1] - capCycle[0] == 10, "R3 character period", capCycle[1] - capCycle[0], 10);
    check(capCycle[5] - capCycle[4] == 10, "R6 period after comma", capCycle[5] - capCycle[4], 10);
    check(syncCount == 2, "R4 sync count", syncCount, 2);
    check(firstSync == 11, "R4 sync timing", firstSync, 11);
    check(minPhase == 10, "R3 phase width", minPhase, 10);

    // Aligned comma on the odd position: dropped, clocks held (R8)
    clearStream();
    pushChar(10'h155); pushChar(K_CH); pushChar(10'h2AA); pushChar(10'h0CC);
    pushChar(10'h333); pushChar(K_CH); pushChar(10'h199);
    pushChar(10'h266); pushChar(10'h155);
    play(1'b1);
    check(capData[0] == 10'h155 && capClk[0], "R8 first char", capData[0], 10'h155);
    check(capData[1] == 10'h2AA && !capClk[1], "R8 comma skipped", capData[1], 10'h2AA);
    check(capCycle[1] == 31, "R8 hold length", capCycle[1], 31);
    check(capData[4] == K_CH, "R8 second comma data", capData[4], K_CH);
    check(capClk[4] == 1'b1, "R8 second comma on byteClk1", capClk[4], 1);
    check(capData[5] == 10'h199 && !capClk[5], "R8 after comma", capData[5], 10'h199);
    check(minPhase >= 10, "R7 no short phase", minPhase, 10);

    // Misaligned comma with alignment enabled (R7, R8)
    buildOffsetStream();
    play(1'b1);
    check(capData[0] == gridWord(0), "R2 bit order word0", capData[0], gridWord(0));
    check(capData[1] == gridWord(1), "R2 bit order word1", capData[1], gridWord(1));
    check(capData[2] == 10'h0CC && capClk[2], "R7 realigned data", capData[2], 10'h0CC);
    check(capCycle[2] - capCycle[1] == 23, "R7 stretch length", capCycle[2] - capCycle[1], 23);
    check(capData[3] == 10'h333 && !capClk[3], "R7 next char", capData[3], 10'h333);
    check(capData[4] == K_CH && capClk[4], "R8 comma on byteClk1", capData[4], K_CH);
    check(capData[5] == 10'h199, "R7 char after comma", capData[5], 10'h199);
    check(capData[6] == 10'h266 && capClk[6], "R7 alternating", capData[6], 10'h266);
    check(syncCount == 2, "R4 sync count offset", syncCount, 2);
    check(minPhase >= 10, "R7 minimum phase", minPhase, 10);

    // Same stream with alignment disabled: grid from reset (R9, R5)
    buildOffsetStream();
    play(1'b0);
    check(capCount >= 8, "R9 capture count", capCount, 8);
    for (int k = 0; k < 8; k++) begin
      check(capData[k] == gridWord(k), "R9 grid word", capData[k], gridWord(k));
      check(capClk[k] == ((k % 2) == 0), "R9 clock alternation", capClk[k], (k % 2) == 0);
    end
    check(capCycle[7] - capCycle[0] == 70, "R9 fixed period", capCycle[7] - capCycle[0], 70);
    check(syncCount == 0, "R5 no sync when disabled", syncCount, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule